// File: doc/BRIEF.md
# Multimode Nine-Bit Serial Port

This block is a single-channel asynchronous serial port for a small controller. Software controls it through a two-address register bus: a data address and a control/status address. A write to the data address sends one frame on the transmit pin. A read of the data address returns the most recent byte the port accepted.

A two-bit mode field picks the frame shape and the rate source. One mode sends plain 8-bit frames. Two modes add a ninth bit. In the nine-bit modes software supplies the outgoing ninth bit, and the port records the incoming one. A multiprocessor filter can discard address-less traffic, so a node on a shared line only wakes up for frames flagged as addresses. Two done flags are set by hardware and cleared by software, and they drive a single interrupt line.

Top module: `serport9`

## Requirements
- R1: After reset the control register reads 0x00, `txd` is 1 and `irq` is 0.
- R2: The control register is at `addr`=1 and the data register at `addr`=0. Control bits from 7 down to 0 are: mode[1], mode[0], mpe (multiprocessor filter), rxen (receive enable), tx9 (outgoing ninth bit), rx9 (captured ninth bit), txdone, rxdone. With mode 00 the port sends nothing and accepts nothing.
- R3: In modes 01 and 11 one bit lasts 16 pulses of `tick_int` when `src_sel`=0, or 16 pulses of `tick_tmr` when `src_sel`=1. In mode 10 one bit lasts 32 clock cycles when `fast`=1 and 64 when `fast`=0.
- R4: A frame is sent LSB first as a start bit 0, eight data bits, then the tx9 value in modes 10 and 11 only, then a stop bit 1. The line idles at 1.
- R5: A data write starts a frame only when the mode is not 00 and no frame is in progress. Any other data write is dropped.
- R6: txdone is set when the stop bit ends. rxdone is set when a frame is accepted. Each flag stays set until software writes 0 to it. `irq` is 1 whenever either flag is 1.
- R7: A data read returns the data byte of the last accepted frame.
- R8: When a frame is accepted, rx9 takes the received ninth bit in modes 10 and 11. In mode 01 it takes the received stop bit.
- R9: A new frame is only started while rxen is 1.
- R10: With mpe=1, a nine-bit frame whose ninth bit is 0 is discarded, and an 8-bit frame whose stop bit is 0 is discarded. A discarded frame changes neither the data register, rx9 nor rxdone.
- R11: No new frame is started while rxdone is 1.
- R12: Each bit is judged by a majority of three samples around mid-bit. A start bit that is not judged 0 is abandoned, and the receiver then waits for the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 selects the data register, 1 selects the control register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register, combinational |
| tick_int | input | 1 | Oversampling pulse from the internal rate generator |
| tick_tmr | input | 1 | Oversampling pulse from the timer overflow |
| src_sel | input | 1 | Rate source for modes 01 and 11 (0 internal, 1 timer) |
| fast | input | 1 | Mode 10 rate: 1 gives clk/32, 0 gives clk/64 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request, OR of the two done flags |

## Verification
Transmit timing is set by the oversampling ticks, so a frame's length is a whole number of bit periods of 16 ticks. The start bit may be up to one tick short, because it begins at the write rather than at a tick. The monitor therefore starts timing from the falling edge on `txd`, samples each bit half a bit period later and then every full period, and reads txdone only after the whole frame plus a margin. A received frame is decided at the middle of its stop bit, about two thirds of a bit after the last data edge. The bench drives one extra idle bit before it reads the data and control registers, so every result is already stable when it is read.

// File: rtl/serport9.sv
module serport9 #(
  parameter int OSR      = 16,
  parameter int FAST_DIV = 32,
  parameter int SLOW_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tick_int,
  input  logic       tick_tmr,
  input  logic       src_sel,
  input  logic       fast,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  localparam int PHW   = $clog2(OSR);
  localparam int FSTEP = FAST_DIV / OSR;
  localparam int SSTEP = SLOW_DIV / OSR;
  localparam int PW    = $clog2(SSTEP + 1);
  localparam logic [PHW-1:0] S0 = PHW'(OSR/2 - 1);
  localparam logic [PHW-1:0] S1 = PHW'(OSR/2);
  localparam logic [PHW-1:0] S2 = PHW'(OSR/2 + 1);
  localparam logic [PHW-1:0] LASTPH = PHW'(OSR - 1);

  logic [1:0] md;
  logic mpe, rxen, tx9, rx9, ti, ri;
  logic [7:0] dbuf;
  logic nine, on, wr_ctl, wr_dat;

  assign nine   = md[1];
  assign on     = |md;
  assign wr_ctl = wr_en & addr;
  assign wr_dat = wr_en & ~addr;

  logic [PW-1:0] pre;
  logic fix_tick, os_tick;

  assign fix_tick = (pre >= PW'((fast ? FSTEP : SSTEP) - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) pre <= '0;
    else if (fix_tick) pre <= '0;
    else pre <= pre + 1'b1;
  end

  always_comb begin
    case (md)
      2'b10:          os_tick = fix_tick;
      2'b01, 2'b11:   os_tick = src_sel ? tick_tmr : tick_int;
      default:        os_tick = 1'b0;
    endcase
  end

  logic tx_busy, tx_fin;
  logic [10:0] tx_sh;
  logic [3:0] tx_left;
  logic [PHW-1:0] tx_ph;

  assign tx_fin = tx_busy & os_tick & (tx_ph == LASTPH) & (tx_left == 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_ph   <= '0;
    end else if (wr_dat && !tx_busy && on) begin
      tx_busy <= 1'b1;
      tx_sh   <= {1'b1, nine ? tx9 : 1'b1, wdata, 1'b0};
      tx_left <= nine ? 4'd11 : 4'd10;
      tx_ph   <= '0;
    end else if (tx_busy && os_tick) begin
      tx_ph <= tx_ph + 1'b1;
      if (tx_ph == LASTPH) begin
        tx_sh   <= {1'b1, tx_sh[10:1]};
        tx_left <= tx_left - 1'b1;
        if (tx_left == 4'd1) tx_busy <= 1'b0;
      end
    end
  end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  logic [2:0] rsync;
  logic rx_s, rx_p;

  always_ff @(posedge clk) begin
    if (!rst_n) rsync <= 3'b111;
    else rsync <= {rsync[1:0], rxd};
  end

  assign rx_s = rsync[1];
  assign rx_p = rsync[2];

  logic rx_on, rx_b9, vote, at_mid, rx_start, rx_last, rx_keep, rx_done;
  logic [3:0] rx_idx;
  logic [PHW-1:0] rx_ph;
  logic [1:0] smp;
  logic [7:0] rx_sh;

  assign rx_start = !rx_on && on && rxen && !ri && rx_p && !rx_s;
  assign vote     = (smp[0] & smp[1]) | (smp[0] & rx_s) | (smp[1] & rx_s);
  assign at_mid   = rx_on && os_tick && (rx_ph == S2);
  assign rx_last  = (rx_idx == (nine ? 4'd10 : 4'd9));
  assign rx_keep  = nine ? (!mpe || rx_b9) : (!mpe || vote);
  assign rx_done  = at_mid && rx_last && rx_keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_on  <= 1'b0;
      rx_idx <= '0;
      rx_ph  <= '0;
      smp    <= '0;
      rx_sh  <= '0;
      rx_b9  <= 1'b0;
    end else if (rx_start) begin
      rx_on  <= 1'b1;
      rx_idx <= '0;
      rx_ph  <= '0;
    end else if (rx_on && os_tick) begin
      rx_ph <= rx_ph + 1'b1;
      if (rx_ph == S0) smp[0] <= rx_s;
      if (rx_ph == S1) smp[1] <= rx_s;
      if (rx_ph == S2) begin
        rx_idx <= rx_idx + 1'b1;
        if (rx_idx == 4'd0) begin
          if (vote) rx_on <= 1'b0;
        end else if (rx_idx <= 4'd8) begin
          rx_sh <= {vote, rx_sh[7:1]};
        end else if (rx_last) begin
          rx_on <= 1'b0;
        end else begin
          rx_b9 <= vote;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {md, mpe, rxen, tx9, rx9, ti, ri} <= '0;
      dbuf <= '0;
    end else begin
      if (wr_ctl) {md, mpe, rxen, tx9, rx9, ti, ri} <= wdata;
      if (tx_fin) ti <= 1'b1;
      if (rx_done) begin
        ri   <= 1'b1;
        rx9  <= nine ? rx_b9 : vote;
        dbuf <= rx_sh;
      end
    end
  end

  assign rdata = addr ? {md, mpe, rxen, tx9, rx9, ti, ri} : dbuf;
  assign irq   = ti | ri;

  // R5
  mode0_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && !on && !tx_busy) |=> !tx_busy);
  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);
  // R6
  ti_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti) |-> ($past(tx_busy) || $past(wr_ctl)));
  // R6
  ri_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri) |-> ($past(rx_on) || $past(wr_ctl)));
  // R6
  ti_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !wr_ctl) |=> ti);
  // R9
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_on && !rxen) |=> !rx_on);
  // R11
  ri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_on && ri) |=> !rx_on);
  // R7
  dbuf_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dbuf) |-> ri);
endmodule

// File: tb/serport9_test.sv
module serport9_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, addr = 1'b0;
  logic tick_int = 1'b0, tick_tmr = 1'b0, src_sel = 1'b0, fast = 1'b0, rxd = 1'b1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic txd, irq;

  always #5 clk = ~clk;

  serport9 uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick_int(tick_int), .tick_tmr(tick_tmr), .src_sel(src_sel),
    .fast(fast), .rxd(rxd), .txd(txd), .irq(irq)
  );

  int checks = 0, errors = 0;
  int bitclk = 64;
  logic [9:0] expq[$];

  initial begin
    int ic, tc;
    ic = 0; tc = 0;
    forever begin
      @(negedge clk);
      ic = (ic + 1) % 4;
      tc = (tc + 1) % 6;
      tick_int = (ic == 0);
      tick_tmr = (tc == 0);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_tx(logic [7:0] d, logic has9, logic b9);
    expq.push_back({has9, b9, d});
    wr(1'b0, d);
  endtask

  task automatic rx_frame(logic [7:0] d, logic has9, logic b9, logic stopv);
    logic [10:0] bits;
    int nb;
    bits = has9 ? {stopv, b9, d, 1'b0} : {1'b1, stopv, d, 1'b0};
    nb = has9 ? 11 : 10;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      rxd = bits[i];
      idle(bitclk - 1);
    end
    @(negedge clk);
    rxd = 1'b1;
    idle(bitclk);
  endtask

  // scoreboard monitor on the transmit line
  initial begin
    logic [10:0] got, want;
    logic [9:0] it;
    int nb;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        if (expq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 actual unexpected frame expected no frame");
          it = 10'h000;
        end else begin
          it = expq.pop_front();
        end
        nb = it[9] ? 11 : 10;
        got = '1;
        idle(bitclk / 2);
        got[0] = txd;
        for (int i = 1; i < nb; i++) begin
          idle(bitclk);
          got[i] = txd;
        end
        want = it[9] ? {1'b1, it[8], it[7:0], 1'b0} : {2'b11, it[7:0], 1'b0};
        chk("R4 R3 frame", got, want);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1
    rd(1'b1, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 txd", txd, 1'b1);
    chk("R1 irq", irq, 1'b0);

    // 8-bit transmit, internal ticks, write during frame dropped
    src_sel = 1'b0; bitclk = 64;
    wr(1'b1, 8'h40);
    send_tx(8'hA5, 1'b0, 1'b0);
    idle(3 * bitclk);
    wr(1'b0, 8'h11);
    idle(8 * bitclk + 20);
    rd(1'b1, v); chk("R6 txdone", v, 8'h42);
    chk("R6 irq set", irq, 1'b1);
    idle(12 * bitclk);
    rd(1'b1, v); chk("R6 txdone held", v, 8'h42);
    wr(1'b1, 8'h40);
    rd(1'b1, v); chk("R6 cleared", v, 8'h40);
    chk("R6 irq clear", irq, 1'b0);

    // mode 11 with timer ticks, ninth bit 1 then 0
    src_sel = 1'b1; bitclk = 96;
    wr(1'b1, 8'hC8);
    send_tx(8'h3C, 1'b1, 1'b1);
    idle(11 * bitclk + 20);
    rd(1'b1, v); chk("R6 txdone m11", v, 8'hCA);
    wr(1'b1, 8'hC0);
    send_tx(8'hC3, 1'b1, 1'b0);
    idle(11 * bitclk + 20);

    // mode 10 fixed rates
    fast = 1'b1; bitclk = 32;
    wr(1'b1, 8'h88);
    send_tx(8'h96, 1'b1, 1'b1);
    idle(11 * bitclk + 20);
    fast = 1'b0; bitclk = 64;
    wr(1'b1, 8'h80);
    send_tx(8'h0F, 1'b1, 1'b0);
    idle(11 * bitclk + 20);
    chk("R4 all frames seen", expq.size(), 0);

    // mode 00 is inert
    src_sel = 1'b0; bitclk = 64;
    wr(1'b1, 8'h10);
    wr(1'b0, 8'h77);
    idle(12 * bitclk);
    rd(1'b1, v); chk("R2 no tx in mode 00", v, 8'h10);
    rx_frame(8'h55, 1'b0, 1'b0, 1'b1);
    rd(1'b1, v); chk("R2 no rx in mode 00", v, 8'h10);
    rd(1'b0, v); chk("R2 data untouched", v, 8'h00);

    // 8-bit reception
    wr(1'b1, 8'h50);
    rx_frame(8'h5A, 1'b0, 1'b0, 1'b1);
    rd(1'b0, v); chk("R7 data", v, 8'h5A);
    rd(1'b1, v); chk("R8 stop into rx9", v, 8'h55);
    chk("R6 irq on rx", irq, 1'b1);
    rx_frame(8'h33, 1'b0, 1'b0, 1'b1);
    rd(1'b0, v); chk("R11 frame ignored while rxdone", v, 8'h5A);
    wr(1'b1, 8'h40);
    rx_frame(8'h66, 1'b0, 1'b0, 1'b1);
    rd(1'b0, v); chk("R9 rxen off data", v, 8'h5A);
    rd(1'b1, v); chk("R9 rxen off ctrl", v, 8'h40);

    // 9-bit reception with filter, timer ticks
    src_sel = 1'b1; bitclk = 96;
    wr(1'b1, 8'hF0);
    rx_frame(8'h99, 1'b1, 1'b0, 1'b1);
    rd(1'b0, v); chk("R10 discarded data", v, 8'h5A);
    rd(1'b1, v); chk("R10 discarded ctrl", v, 8'hF0);
    rx_frame(8'h24, 1'b1, 1'b1, 1'b1);
    rd(1'b0, v); chk("R10 address frame data", v, 8'h24);
    rd(1'b1, v); chk("R8 ninth 1", v, 8'hF5);
    wr(1'b1, 8'hD0);
    rx_frame(8'hE1, 1'b1, 1'b0, 1'b1);
    rd(1'b0, v); chk("R7 nine-bit data", v, 8'hE1);
    rd(1'b1, v); chk("R8 ninth 0", v, 8'hD1);

    // 8-bit filter on stop bit
    src_sel = 1'b0; bitclk = 64;
    wr(1'b1, 8'h70);
    rx_frame(8'h42, 1'b0, 1'b0, 1'b0);
    rd(1'b1, v); chk("R10 bad stop ctrl", v, 8'h70);
    rd(1'b0, v); chk("R10 bad stop data", v, 8'hE1);
    rx_frame(8'h42, 1'b0, 1'b0, 1'b1);
    rd(1'b0, v); chk("R10 good stop data", v, 8'h42);
    rd(1'b1, v); chk("R10 good stop ctrl", v, 8'h75);

    // glitch on the line
    wr(1'b1, 8'h50);
    @(negedge clk); rxd = 1'b0;
    idle(8);
    rxd = 1'b1;
    idle(12 * bitclk);
    rd(1'b1, v); chk("R12 glitch rejected", v, 8'h50);
    rx_frame(8'hC7, 1'b0, 1'b0, 1'b1);
    rd(1'b0, v); chk("R12 frame after glitch", v, 8'hC7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule